// File: doc/BRIEF.md
# Audio Block Preamble Sequencer

This block decides which preamble type each sub-frame of a two-channel digital audio transmitter carries. The transmitter groups its frames into fixed blocks of 192 frames, which is 384 sub-frames. A one-cycle strobe marks the start of every sub-frame. On each strobe the sequencer registers the preamble code for that sub-frame, a flag that is high only for the sub-frame that opens a block, and the index of the frame that the sub-frame belongs to.

The order of preambles is fixed and cannot be programmed. The sub-frame that opens a block carries Z and the next one carries Y. After that, X and Y alternate until the block ends, and the next block opens with Z again. Dropping the enable returns the sequencer to the start of a block, so the first sub-frame sent after enable is raised again is always a Z sub-frame.

Top module: `preamble_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pre_code` is 2'b00, `blk_start` is 0 and `frame_idx` is 0.
- R2: The first `sf_strobe` taken while `en` is high after reset or after a disable yields `pre_code` = 2'b00 (Z), `blk_start` = 1 and `frame_idx` = 0, visible on the cycle after the strobe.
- R3: The strobe that follows the Z sub-frame yields `pre_code` = 2'b10 (Y) with `blk_start` = 0.
- R4: Within a block, sub-frame position p > 0 yields Y (2'b10) when p is odd and X (2'b01) when p is even.
- R5: A block has 384 sub-frames. The strobe after position 383 yields Z with `blk_start` = 1 and `frame_idx` = 0 again.
- R6: `frame_idx` equals the sub-frame position divided by two, ranging from 0 to 191.
- R7: On a cycle with `en` high and `sf_strobe` low, all outputs hold their values and the position does not advance.
- R8: On a cycle with `en` low, the position returns to 0, strobes are ignored, and on the next cycle the outputs show `pre_code` = 2'b00, `blk_start` = 0 and `frame_idx` = 0.
- R9: `blk_start` is high only while `pre_code` is Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmitter enable. Low clears the sequence |
| sf_strobe | input | 1 | One-cycle pulse at the start of each sub-frame |
| pre_code | output | 2 | Preamble code: 00 = Z, 01 = X, 10 = Y |
| blk_start | output | 1 | High during the sub-frame that opens a block |
| frame_idx | output | 8 | Frame index within the block, 0 to 191 |

## Verification
The bench walks several complete blocks across the wrap from position 383 to 0. A design that counts to 384 or misses the wrap would send an extra sub-frame, or an X or Y where Z belongs. It drops `en` at random points in the middle of a block. A design that fails to clear the position would resume with X or Y instead of Z. Random gaps between strobes show whether the design advances on idle cycles. A wrong Z-to-Y pair, or a frame index off by one at odd positions, shows up as a mismatch against the bench's own position model.

// File: rtl/preamble_seq_pkg.sv
package preamble_seq_pkg;
  typedef enum logic [1:0] {
    PRE_Z = 2'b00,
    PRE_X = 2'b01,
    PRE_Y = 2'b10
  } pre_e;
endpackage

// File: rtl/ps_pos_counter.sv
module ps_pos_counter #(
  parameter int SUBF = 384,
  localparam int CW = $clog2(SUBF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          sf_strobe,
  output logic [CW-1:0] pos
);
  localparam logic [CW-1:0] LAST = CW'(SUBF - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos <= '0;
    end else if (sf_strobe) begin
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/ps_decode.sv
module ps_decode
  import preamble_seq_pkg::*;
#(
  parameter int SUBF = 384,
  localparam int CW = $clog2(SUBF),
  localparam int FW = CW - 1
) (
  input  logic [CW-1:0] pos,
  output pre_e          code,
  output logic          first,
  output logic [FW-1:0] fidx
);
  always_comb begin
    first = (pos == '0);
    if (first)       code = PRE_Z;
    else if (pos[0]) code = PRE_Y;
    else             code = PRE_X;
    fidx = pos[CW-1:1];
  end
endmodule

// File: rtl/preamble_seq.sv
module preamble_seq
  import preamble_seq_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int SUBF = 2 * FRAMES,
  localparam int CW = $clog2(SUBF),
  localparam int FW = CW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          sf_strobe,
  output logic [1:0]    pre_code,
  output logic          blk_start,
  output logic [FW-1:0] frame_idx
);
  logic [CW-1:0] pos;
  pre_e          nxt_code;
  logic          nxt_first;
  logic [FW-1:0] nxt_fidx;

  ps_pos_counter #(.SUBF(SUBF)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .sf_strobe(sf_strobe), .pos(pos)
  );

  ps_decode #(.SUBF(SUBF)) u_dec (
    .pos(pos), .code(nxt_code), .first(nxt_first), .fidx(nxt_fidx)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre_code  <= PRE_Z;
      blk_start <= 1'b0;
      frame_idx <= '0;
    end else if (sf_strobe) begin
      pre_code  <= nxt_code;
      blk_start <= nxt_first;
      frame_idx <= nxt_fidx;
    end
  end
endmodule

// File: rtl/preamble_seq_chk.sv
module preamble_seq_chk #(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(2 * FRAMES) - 1
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          sf_strobe,
  input logic [1:0]    pre_code,
  input logic          blk_start,
  input logic [FW-1:0] frame_idx
);
  localparam logic [FW-1:0] LAST_F = FW'(FRAMES - 1);

  p_blk_only_z_r9: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> pre_code == 2'b00);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !sf_strobe) |=> ($stable(pre_code) && $stable(blk_start) && $stable(frame_idx)));

  p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pre_code == 2'b00 && !blk_start && frame_idx == '0));

  p_z_then_y_r3: assert property (@(posedge clk) disable iff (rst)
    (en && sf_strobe && blk_start) |=> (pre_code == 2'b10 && frame_idx == '0));

  p_x_then_y_r4: assert property (@(posedge clk) disable iff (rst)
    (en && sf_strobe && pre_code == 2'b01) |=> (pre_code == 2'b10 && frame_idx == $past(frame_idx)));

  p_frame_step_r6: assert property (@(posedge clk) disable iff (rst)
    (en && sf_strobe && pre_code == 2'b10 && frame_idx != LAST_F)
      |=> (pre_code == 2'b01 && frame_idx == $past(frame_idx) + 1'b1));

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (en && sf_strobe && pre_code == 2'b10 && frame_idx == LAST_F)
      |=> (pre_code == 2'b00 && blk_start && frame_idx == '0));
endmodule

bind preamble_seq preamble_seq_chk #(.FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst(rst), .en(en), .sf_strobe(sf_strobe),
  .pre_code(pre_code), .blk_start(blk_start), .frame_idx(frame_idx)
);

// File: tb/tb_preamble_seq.sv
module tb_preamble_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES = 192;
  localparam int SUBF = 2 * FRAMES;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       sf_strobe = 1'b0;
  logic [1:0] pre_code;
  logic       blk_start;
  logic [7:0] frame_idx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int  m_pos = 0;
  int  m_code = 0;
  int  m_blk = 0;
  int  m_frame = 0;
  bit  m_wrap = 0;

  preamble_seq #(.FRAMES(FRAMES)) dut (
    .clk(clk), .rst(rst), .en(en), .sf_strobe(sf_strobe),
    .pre_code(pre_code), .blk_start(blk_start), .frame_idx(frame_idx)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int code_for(int p);
    if (p == 0) return 0;
    return (p % 2 == 1) ? 2 : 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step(bit e, bit s);
    string tag;
    en = e;
    sf_strobe = s;
    @(posedge clk);
    if (!e) begin
      m_pos = 0; m_code = 0; m_blk = 0; m_frame = 0;
      tag = "R8";
    end else if (s) begin
      m_code = code_for(m_pos);
      m_blk = (m_pos == 0) ? 1 : 0;
      m_frame = m_pos / 2;
      if (m_pos == 0) tag = m_wrap ? "R5" : "R2";
      else if (m_pos == 1) tag = "R3";
      else tag = "R4";
      m_wrap = (m_pos == SUBF - 1);
      m_pos = (m_pos == SUBF - 1) ? 0 : m_pos + 1;
    end else begin
      tag = "R7";
    end
    if (!e) m_wrap = 0;
    #1;
    check(tag, int'(pre_code), m_code);
    check(tag, int'(blk_start), m_blk);
    check("R6", int'(frame_idx), m_frame);
    check("R9", int'(blk_start && pre_code != 2'b00), 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", int'(pre_code), 0);
    check("R1", int'(blk_start), 0);
    check("R1", int'(frame_idx), 0);
    rst = 1'b0;
    #1;
    check("R1", int'(pre_code), 0);
    @(negedge clk);

    // Directed: first Z, Y, X with idle cycles between
    step(1, 0);
    step(1, 1);
    step(1, 0);
    step(1, 1);
    step(1, 1);
    step(1, 0);
    // Directed: strobe while disabled is ignored, then restart on Z
    step(0, 1);
    step(1, 1);
    step(1, 1);

    // Two full blocks back to back across the wrap
    for (int i = 0; i < 2 * SUBF + 4; i++) step(1, 1);

    // Random gaps, occasional disable
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 1) step(0, ($urandom % 2) == 1);
      else step(1, r < 70);
    end

    // Drop enable mid-block then restart
    for (int i = 0; i < 100; i++) step(1, 1);
    step(0, 0);
    step(1, 1);
    step(1, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule